// File: doc/BRIEF.md
# Halfword signed multiply-accumulate unit

This block is a one-stage DSP datapath. It multiplies signed operands taken from two 32-bit words and adds a 32-bit signed accumulator word. There are two operating modes. In halfword mode, a select bit picks one 16-bit half of each source word, and the two halves are multiplied into a 32-bit product. In word mode, the whole first word is multiplied by one selected half of the second word. The resulting 48-bit product is then shifted right by sixteen, so that only its upper 32 bits reach the adder.

The caller presents the operands, the accumulator, the mode and the two half selects together with a valid strobe. One clock later the wrapped 32-bit sum appears, qualified by a result strobe. A sticky flag records any signed overflow of the accumulate addition, in either mode. It stays set until a dedicated clear input or reset removes it. The multiplication itself cannot overflow in either mode.

Top module: `half_mac`

## Requirements
- R1: `sel_x` picks the half of `op_a` and `sel_y` picks the half of `op_b`, each independently: 0 selects bits [15:0] and 1 selects bits [31:16]. The half that is not selected has no effect on the result.
- R2: With `mode`=0 (halfword mode), the result is the signed 16-bit half of `op_a` times the signed 16-bit half of `op_b`, plus `acc` as a signed value, truncated to 32 bits.
- R3: With `mode`=1 (word mode), `op_a` as a signed word is multiplied by the signed half of `op_b` chosen by `sel_y`. Bits [47:16] of the 48-bit product are added to `acc`. `sel_x` has no effect in this mode.
- R4: When the addition overflows, `res` holds the wrapped two's-complement sum and is not saturated.
- R5: An accepted operation sets `ovf_sticky` on the next clock when both addends share a sign and the 32-bit sum has the other sign. This applies in both modes.
- R6: Once set, `ovf_sticky` stays set through later operations that do not overflow and through idle cycles.
- R7: `ovf_clr` clears `ovf_sticky` on the next clock. If an accepted operation overflows in the same cycle, the flag is set instead.
- R8: `res` and `res_valid` follow `in_valid` by exactly one clock. `res_valid` is low after a cycle without `in_valid`, and `res` then keeps its last value.
- R9: While `rst_n` is low, `res`, `res_valid` and `ovf_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| mode | input | 1 | 0 halfword by halfword, 1 word by halfword |
| sel_x | input | 1 | Half select for `op_a` (halfword mode only) |
| sel_y | input | 1 | Half select for `op_b` |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| acc | input | 32 | Accumulator addend |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe |
| ovf_sticky | output | 1 | Sticky accumulate-overflow flag |

## Verification
The hardest case to reach is overflow in word mode. There the product is scaled down by 2^16, so only an accumulator close to either end of the signed range can push the sum out of range. The operand sweep therefore combines extreme halfwords (0x7FFF, 0x8000, 0xFFFF) with accumulators just below the positive limit and just above the negative limit. This produces overflow in both directions in both modes. A directed step also drives an overflowing operation in the same cycle as `ovf_clr`, to expose the priority between setting and clearing the flag.

// File: rtl/half_mac_pkg.sv
package half_mac_pkg;

  typedef enum logic {
    MODE_HALF_HALF = 1'b0,
    MODE_WORD_HALF = 1'b1
  } mac_mode_e;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_sel_e;

endpackage

// File: rtl/hm_half_pick.sv
module hm_half_pick #(
  parameter int W = 32
) (
  input  logic [W-1:0]   word_i,
  input  logic           high_i,
  output logic [W/2-1:0] half_o
);
  import half_mac_pkg::*;

  localparam int H = W / 2;

  half_sel_e which;

  function automatic logic [H-1:0] pick(input logic [W-1:0] w, input half_sel_e s);
    return (s == HALF_HIGH) ? w[W-1:H] : w[H-1:0];
  endfunction

  assign which  = half_sel_e'(high_i);
  assign half_o = pick(word_i, which);

endmodule

// File: rtl/hm_product.sv
module hm_product #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_word_i,
  input  logic [W/2-1:0] x_half_i,
  input  logic [W/2-1:0] y_half_i,
  input  logic           wide_i,
  output logic [W-1:0]   addend_o
);
  localparam int H  = W / 2;
  localparam int PW = W + H;

  // Signed half times signed half; the product always fits in W bits.
  function automatic logic [W-1:0] mul_half_half(input logic [H-1:0] x, input logic [H-1:0] y);
    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;
    logic signed [W-1:0] p;
    xs = $signed({{H{x[H-1]}}, x});
    ys = $signed({{H{y[H-1]}}, y});
    p  = xs * ys;
    return p;
  endfunction

  // Signed word times signed half; keep the upper W bits of the PW-bit product.
  function automatic logic [W-1:0] mul_word_half(input logic [W-1:0] a, input logic [H-1:0] y);
    logic signed [PW-1:0] as_;
    logic signed [PW-1:0] ys;
    logic signed [PW-1:0] p;
    as_ = $signed({{H{a[W-1]}}, a});
    ys  = $signed({{W{y[H-1]}}, y});
    p   = as_ * ys;
    return p[PW-1:H];
  endfunction

  logic [W-1:0] p_hh;
  logic [W-1:0] p_wh;

  assign p_hh     = mul_half_half(x_half_i, y_half_i);
  assign p_wh     = mul_word_half(a_word_i, y_half_i);
  assign addend_o = wide_i ? p_wh : p_hh;

endmodule

// File: rtl/hm_accum.sv
module hm_accum #(
  parameter int W = 32
) (
  input  logic [W-1:0] prod_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);

  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] p, input logic [W-1:0] q);
    return p + q;
  endfunction

  // Same-sign addends producing an opposite-sign sum.
  function automatic logic add_overflows(input logic [W-1:0] p, input logic [W-1:0] q,
                                         input logic [W-1:0] s);
    return (p[W-1] == q[W-1]) && (s[W-1] != p[W-1]);
  endfunction

  assign sum_o = wrap_add(prod_i, acc_i);
  assign ovf_o = add_overflows(prod_i, acc_i, sum_o);

endmodule

// File: rtl/half_mac.sv
module half_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         mode,
  input  logic         sel_x,
  input  logic         sel_y,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] acc,
  input  logic         ovf_clr,
  output logic [W-1:0] res,
  output logic         res_valid,
  output logic         ovf_sticky
);
  import half_mac_pkg::*;

  localparam int H = W / 2;

  mac_mode_e    mode_e;
  logic         wide;
  logic [H-1:0] x_half;
  logic [H-1:0] y_half;
  logic [W-1:0] addend;
  logic [W-1:0] acc_sum;
  logic         sum_ovf;
  logic         ovf_event;

  logic [W-1:0] res_q;
  logic         vld_q;
  logic         flag_q;

  assign mode_e = mac_mode_e'(mode);
  assign wide   = (mode_e == MODE_WORD_HALF);

  hm_half_pick #(.W(W)) u_pick_x (
    .word_i (op_a),
    .high_i (sel_x),
    .half_o (x_half)
  );

  hm_half_pick #(.W(W)) u_pick_y (
    .word_i (op_b),
    .high_i (sel_y),
    .half_o (y_half)
  );

  hm_product #(.W(W)) u_product (
    .a_word_i (op_a),
    .x_half_i (x_half),
    .y_half_i (y_half),
    .wide_i   (wide),
    .addend_o (addend)
  );

  hm_accum #(.W(W)) u_accum (
    .prod_i (addend),
    .acc_i  (acc),
    .sum_o  (acc_sum),
    .ovf_o  (sum_ovf)
  );

  assign ovf_event = in_valid && sum_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      vld_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= acc_sum;
      end
      if (ovf_event) begin
        flag_q <= 1'b1;
      end else if (ovf_clr) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign res        = res_q;
  assign res_valid  = vld_q;
  assign ovf_sticky = flag_q;

endmodule

// File: rtl/half_mac_chk.sv
module half_mac_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         ovf_clr,
  input logic         ovf_event,
  input logic [W-1:0] acc_sum,
  input logic [W-1:0] res,
  input logic         res_valid,
  input logic         ovf_sticky
);

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R8
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  // R8
  result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res == $past(acc_sum)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));

  // R5
  overflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_sticky);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  // R7
  overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_event) |=> !ovf_sticky);

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (res_valid == 1'b0 && ovf_sticky == 1'b0);
    end
  end

endmodule

bind half_mac half_mac_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .ovf_clr    (ovf_clr),
  .ovf_event  (ovf_event),
  .acc_sum    (acc_sum),
  .res        (res),
  .res_valid  (res_valid),
  .ovf_sticky (ovf_sticky)
);

// File: tb/half_mac_tb.sv
module half_mac_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic        sel_x = 1'b0;
  logic        sel_y = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] acc = '0;
  logic        ovf_clr = 1'b0;
  logic [31:0] res;
  logic        res_valid;
  logic        ovf_sticky;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic        sticky_exp = 1'b0;
  logic [31:0] last_res = '0;

  localparam longint MAXP = 64'sh7FFFFFFF;
  localparam longint MINN = -(64'sh80000000);

  always #5 clk = ~clk;

  half_mac u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .sel_x      (sel_x),
    .sel_y      (sel_y),
    .op_a       (op_a),
    .op_b       (op_b),
    .acc        (acc),
    .ovf_clr    (ovf_clr),
    .res        (res),
    .res_valid  (res_valid),
    .ovf_sticky (ovf_sticky)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint s16(input logic [15:0] h);
    return longint'($signed(h));
  endfunction

  function automatic longint s32(input logic [31:0] w);
    return longint'($signed(w));
  endfunction

  // Reference: full-precision sum, then the wrap and the range test.
  task automatic model(input logic m, input logic sx, input logic sy, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c,
                       output logic [31:0] r, output logic o);
    longint xv, yv, full;
    xv = sx ? s16(a[31:16]) : s16(a[15:0]);
    yv = sy ? s16(b[31:16]) : s16(b[15:0]);
    if (m) full = ((s32(a) * yv) >>> 16) + s32(c);
    else   full = (xv * yv) + s32(c);
    r = full[31:0];
    o = (full > MAXP) || (full < MINN);
  endtask

  task automatic run_op(input logic m, input logic sx, input logic sy, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input logic clr,
                        output logic [31:0] got);
    logic [31:0] er;
    logic        eo;
    model(m, sx, sy, a, b, c, er, eo);
    @(negedge clk);
    in_valid = 1'b1; mode = m; sel_x = sx; sel_y = sy;
    op_a = a; op_b = b; acc = c; ovf_clr = clr;
    @(negedge clk);
    if (eo) sticky_exp = 1'b1;
    else if (clr) sticky_exp = 1'b0;
    check("R8 res_valid after op", {31'b0, res_valid}, 32'd1);
    check(m ? "R3 word-mode result" : "R2 half-mode result", res, er);
    check(eo ? "R5 overflow flag" : "R6 flag held", {31'b0, ovf_sticky}, {31'b0, sticky_exp});
    got = res;
    last_res = res;
    in_valid = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic idle(input logic clr);
    @(negedge clk);
    in_valid = 1'b0; ovf_clr = clr;
    op_a = ~op_a; acc = ~acc;
    @(negedge clk);
    if (clr) sticky_exp = 1'b0;
    check("R8 res_valid idle", {31'b0, res_valid}, 32'd0);
    check("R8 res held idle", res, last_res);
    check(clr ? "R7 flag cleared" : "R6 flag held idle", {31'b0, ovf_sticky}, {31'b0, sticky_exp});
    ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] hv [8];
    logic [31:0] av [3];
    logic [31:0] g0, g1;
    int n;
    hv[0] = 16'h0000; hv[1] = 16'h0001; hv[2] = 16'hFFFF; hv[3] = 16'h7FFF;
    hv[4] = 16'h8000; hv[5] = 16'h1234; hv[6] = 16'hA5C3; hv[7] = 16'h4000;
    av[0] = 32'h0000_0000; av[1] = 32'h7FFF_FFF0; av[2] = 32'h8000_0005;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 res in reset", res, 32'd0);
    check("R9 res_valid in reset", {31'b0, res_valid}, 32'd0);
    check("R9 flag in reset", {31'b0, ovf_sticky}, 32'd0);
    rst_n = 1'b1;

    // R4 / R5: positive wrap in halfword mode
    run_op(1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, g0);
    check("R4 wrapped result", g0, 32'h8000_0000);
    check("R5 flag set", {31'b0, ovf_sticky}, 32'd1);
    // R6: non-overflowing op and idle keep the flag
    run_op(1'b0, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'h0, 1'b0, g0);
    check("R6 flag survives op", {31'b0, ovf_sticky}, 32'd1);
    idle(1'b0);
    idle(1'b1);
    // R7: clear collides with an overflowing op: the set wins
    run_op(1'b1, 1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000, 1'b1, g0);
    check("R7 set beats clear", {31'b0, ovf_sticky}, 32'd1);
    idle(1'b1);

    // R1: unselected halves have no effect
    run_op(1'b0, 1'b1, 1'b0, 32'h8001_1111, 32'h2222_7FFF, 32'h10, 1'b0, g0);
    run_op(1'b0, 1'b1, 1'b0, 32'h8001_EEEE, 32'hDDDD_7FFF, 32'h10, 1'b0, g1);
    check("R1 unselected halves ignored", g1, g0);
    // R3: sel_x ignored in word mode
    run_op(1'b1, 1'b0, 1'b1, 32'h1234_5678, 32'h8000_0001, 32'h5, 1'b0, g0);
    run_op(1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h8000_0001, 32'h5, 1'b0, g1);
    check("R3 sel_x ignored in word mode", g1, g0);
    idle(1'b1);

    // R2 / R3 / R5: sweep of halves, selects, modes and accumulators
    n = 0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int s = 0; s < 8; s++) begin
          for (int k = 0; k < 3; k++) begin
            run_op(s[2], s[1], s[0], {hv[i], hv[(i + 3) % 8]}, {hv[j], hv[(j + 5) % 8]},
                   av[k], 1'b0, g0);
            n++;
            if ((n % 4) == 0) idle(1'b1);
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule